// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block is a two-entry prefetch buffer that sits beside a direct-mapped data cache. Every CPU reference is presented to the buffer in the same cycle it is presented to the cache. The buffer compares the block address of the reference against its stored tags and answers in that cycle. When a stored block matches, the buffer drives it onto a fill port so that the cache can install it, and the buffer entry becomes free again. Blocks are never served to the CPU from the buffer itself.

Independently of hit or miss, every reference to block B retargets prefetching to block B+1. If B+1 is already held or already on its way, nothing happens. Otherwise an entry is claimed for it: a free entry if one exists, else the entry named by a round-robin pointer. Any stale block or stale fetch in that entry is discarded. The buffer then issues a block read on a simple request/response memory port. It yields that port in any cycle where the reference missed both the cache and the buffer, so that the cache's own demand fetch goes first.

A block is eight 32-bit words (32 bytes). All addresses on the ports are byte addresses, and the low five bits select a byte within the block.

Top module: `stream_pf_buf`

## Requirements
- R1: After reset every entry is empty: no memory request is raised and no lookup hits until a block has been fetched.
- R2: When a reference's block address (byte address bits 31:5) equals the tag of a filled entry, lk_buf_hit is high in the same cycle. If lk_cache_hit is low in that cycle, fill_valid is high, fill_addr is the block-aligned address and fill_data is the stored block, with word w in bits 32*w+31:32*w. If lk_cache_hit is high, fill_valid stays low.
- R3: A buffer hit frees its entry, so a second reference to the same block in the next cycle does not hit.
- R4: A reference to block B claims an entry for block B+1, with the block number wrapping to zero past the top. A request for it appears on the memory port no earlier than the next cycle.
- R5: No entry is claimed and no request is made when block B+1 is already filled or already requested or awaiting data.
- R6: The claimed entry is the lowest-numbered free entry, counting an entry freed by a hit in the same cycle as free. If no entry is free, the claimed entry is the one named by a round-robin pointer, which then advances.
- R7: mem_req_valid is low in every cycle in which a reference misses both the cache and the buffer.
- R8: A memory response is stored only into an entry that is awaiting data with the same block address. A response for a block whose entry has been overwritten is dropped.
- R9: Memory request addresses are block-aligned byte addresses, with bits 4:0 zero. The offset bits of lk_addr and mem_rsp_addr are ignored.
- R10: A request accepted with mem_req_ready high is issued once. The same block is not requested again in the following cycle. When several entries wait to issue, the lowest-numbered one goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A CPU reference is presented this cycle |
| lk_addr | input | 32 | Byte address of the reference |
| lk_cache_hit | input | 1 | The cache's own lookup hit for this reference |
| lk_buf_hit | output | 1 | The buffer holds the referenced block |
| fill_valid | output | 1 | Block transfer into the cache this cycle |
| fill_addr | output | 32 | Block-aligned byte address of the transferred block |
| fill_data | output | 256 | Transferred block, word 0 in the low bits |
| mem_req_valid | output | 1 | Prefetch block read request |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Block-aligned byte address to read |
| mem_rsp_valid | input | 1 | Block read data is returned this cycle |
| mem_rsp_addr | input | 32 | Byte address of the returned block |
| mem_rsp_data | input | 256 | Returned block, word 0 in the low bits |

## Verification
The assertions assume that memory returns only blocks it was asked for. They also assume that lk_cache_hit carries meaning only while lk_valid is high. Nothing is assumed about response latency or about when mem_req_ready rises. The stimulus keeps to this with a bench memory that answers accepted requests in order after a fixed delay, and can hold its responses back. Holding them back lets entries be overwritten while their reads are outstanding, so stale responses arrive and must be dropped. The random phase mixes ascending block runs with jumps and toggles ready and the cache-hit flag. The block-number wrap is covered by a reference to the last block.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    // Life cycle of one buffer entry
    typedef enum logic [1:0] {
        ENT_EMPTY = 2'd0,   // free
        ENT_REQ   = 2'd1,   // claimed, read not yet accepted by memory
        ENT_WAIT  = 2'd2,   // read accepted, data outstanding
        ENT_FULL  = 2'd3    // block held
    } ent_st_e;

    // Which per-entry condition a tag comparator reports
    typedef enum int {
        CMP_FULL = 0,       // tag matches and block is held
        CMP_LIVE = 1,       // tag matches and entry is not free
        CMP_WAIT = 2        // tag matches and data is outstanding
    } cmp_mode_e;

endpackage

// File: rtl/pfb_match.sv
module pfb_match
    import pfb_pkg::*;
#(
    parameter int        NUM_ENT = 2,
    parameter int        TAG_W   = 27,
    parameter cmp_mode_e MODE    = CMP_FULL
) (
    input  ent_st_e [NUM_ENT-1:0]            st,
    input  logic    [NUM_ENT-1:0][TAG_W-1:0] tags,
    input  logic    [TAG_W-1:0]              key,
    output logic    [NUM_ENT-1:0]            match_vec
);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic tag_eq;
        assign tag_eq = (tags[e] == key);
        if (MODE == CMP_FULL) begin : g_full
            assign match_vec[e] = tag_eq && (st[e] == ENT_FULL);
        end else if (MODE == CMP_LIVE) begin : g_live
            assign match_vec[e] = tag_eq && (st[e] != ENT_EMPTY);
        end else begin : g_wait
            assign match_vec[e] = tag_eq && (st[e] == ENT_WAIT);
        end
    end

endmodule

// File: rtl/pfb_pick.sv
module pfb_pick #(
    parameter int NUM_ENT = 2,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] cand,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Lowest-numbered candidate wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/stream_pf_buf.sv
module stream_pf_buf
    import pfb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 8,
    parameter int NUM_ENT   = 2,
    localparam int BLK_BYTES = BLK_WORDS * WORD_W / 8,
    localparam int OFS_W     = $clog2(BLK_BYTES),
    localparam int TAG_W     = ADDR_W - OFS_W,
    localparam int LINE_W    = BLK_WORDS * WORD_W,
    localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_cache_hit,
    output logic              lk_buf_hit,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LINE_W-1:0] fill_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [LINE_W-1:0] mem_rsp_data
);

    typedef struct packed {
        ent_st_e [NUM_ENT-1:0]             st;
        logic    [NUM_ENT-1:0][TAG_W-1:0]  tag;
        logic    [NUM_ENT-1:0][LINE_W-1:0] line;
        logic    [IDX_W-1:0]               rr;
    } state_t;

    state_t s_q, s_d;

    logic [TAG_W-1:0]   lk_tag, tgt_tag, rsp_tag;
    logic [NUM_ENT-1:0] lk_full_vec, lk_hit_vec, tgt_live_vec, rsp_wait_vec;
    logic [NUM_ENT-1:0] req_vec, free_vec;
    logic               req_found, free_found;
    logic [IDX_W-1:0]   req_idx, free_idx;
    logic               buf_hit, yield_port, req_fire;
    logic               unused_ofs;

    assign lk_tag     = lk_addr[ADDR_W-1:OFS_W];
    assign tgt_tag    = lk_tag + 1'b1;
    assign rsp_tag    = mem_rsp_addr[ADDR_W-1:OFS_W];
    assign unused_ofs = ^{lk_addr[OFS_W-1:0], mem_rsp_addr[OFS_W-1:0]};

    // Parallel lookup of the referenced block
    pfb_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .MODE(CMP_FULL)) u_lk_match (
        .st        (s_q.st),
        .tags      (s_q.tag),
        .key       (lk_tag),
        .match_vec (lk_full_vec)
    );

    // Is the successor block already held or on its way
    pfb_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .MODE(CMP_LIVE)) u_tgt_match (
        .st        (s_q.st),
        .tags      (s_q.tag),
        .key       (tgt_tag),
        .match_vec (tgt_live_vec)
    );

    // Which entry (if any) still expects the returned block
    pfb_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .MODE(CMP_WAIT)) u_rsp_match (
        .st        (s_q.st),
        .tags      (s_q.tag),
        .key       (rsp_tag),
        .match_vec (rsp_wait_vec)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_vec
        assign lk_hit_vec[e] = lk_valid && lk_full_vec[e];
        assign req_vec[e]    = (s_q.st[e] == ENT_REQ);
        assign free_vec[e]   = (s_q.st[e] == ENT_EMPTY) || lk_hit_vec[e];
    end

    pfb_pick #(.NUM_ENT(NUM_ENT)) u_req_pick (
        .cand  (req_vec),
        .found (req_found),
        .idx   (req_idx)
    );

    pfb_pick #(.NUM_ENT(NUM_ENT)) u_free_pick (
        .cand  (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    assign buf_hit    = |lk_hit_vec;
    assign yield_port = lk_valid && !lk_cache_hit && !buf_hit;
    assign req_fire   = mem_req_valid && mem_req_ready;

    // Outputs
    assign lk_buf_hit    = buf_hit;
    assign fill_valid    = buf_hit && !lk_cache_hit;
    assign fill_addr     = {lk_tag, {OFS_W{1'b0}}};
    assign mem_req_valid = req_found && !yield_port;
    assign mem_req_addr  = {s_q.tag[req_idx], {OFS_W{1'b0}}};

    always_comb begin
        fill_data = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (lk_hit_vec[e]) begin
                fill_data = fill_data | s_q.line[e];
            end
        end
    end

    // Next-state computation
    always_comb begin
        logic [IDX_W-1:0] victim;
        s_d    = s_q;
        victim = free_idx;

        // returned data lands only where its block is still awaited
        if (mem_rsp_valid) begin
            for (int e = 0; e < NUM_ENT; e++) begin
                if (rsp_wait_vec[e]) begin
                    s_d.st[e]   = ENT_FULL;
                    s_d.line[e] = mem_rsp_data;
                end
            end
        end

        // accepted read now waits for data
        if (req_fire) begin
            s_d.st[req_idx] = ENT_WAIT;
        end

        // a hit moves the block to the cache and frees the entry
        for (int e = 0; e < NUM_ENT; e++) begin
            if (lk_hit_vec[e]) begin
                s_d.st[e] = ENT_EMPTY;
            end
        end

        // retarget prefetching to the successor block
        if (lk_valid && !(|tgt_live_vec)) begin
            if (!free_found) begin
                victim = s_q.rr;
                if (s_q.rr == IDX_W'(NUM_ENT - 1)) begin
                    s_d.rr = '0;
                end else begin
                    s_d.rr = s_q.rr + 1'b1;
                end
            end
            s_d.st[victim]  = ENT_REQ;
            s_d.tag[victim] = tgt_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_cache_hit,
    input logic              lk_buf_hit,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr
);

    // R1: first cycle out of reset raises no request
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !mem_req_valid);

    // R2: a fill needs a buffer hit on a cache miss
    a_r2_fill_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (lk_buf_hit && !lk_cache_hit && lk_valid));

    // R2: hits only occur on a presented reference
    a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        lk_buf_hit |-> lk_valid);

    // R2: fill address is the referenced block
    a_r2_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (fill_addr[ADDR_W-1:OFS_W] == lk_addr[ADDR_W-1:OFS_W]));

    // R3: a hit frees its entry
    a_r3_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        lk_buf_hit |=> !(lk_buf_hit &&
            lk_addr[ADDR_W-1:OFS_W] == $past(lk_addr[ADDR_W-1:OFS_W])));

    // R7: demand miss owns the memory port
    a_r7_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_cache_hit && !lk_buf_hit) |-> !mem_req_valid);

    // R9: requests are block aligned
    a_r9_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFS_W-1:0] == '0));

    // R10: an accepted block is not requested again right away
    a_r10_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=>
            !(mem_req_valid && mem_req_addr == $past(mem_req_addr)));

endmodule

bind stream_pf_buf pfb_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_addr       (lk_addr),
    .lk_cache_hit  (lk_cache_hit),
    .lk_buf_hit    (lk_buf_hit),
    .fill_valid    (fill_valid),
    .fill_addr     (fill_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/stream_pf_buf_tb.sv
module stream_pf_buf_tb;

    localparam int TW  = 27;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_cache_hit = 1'b0;
    logic         lk_buf_hit;
    logic         fill_valid;
    logic [31:0]  fill_addr;
    logic [255:0] fill_data;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_addr = '0;
    logic [255:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    stream_pf_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_cache_hit(lk_cache_hit),
        .lk_buf_hit(lk_buf_hit), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr),
        .mem_rsp_data(mem_rsp_data)
    );

    int total = 0;
    int bad = 0;
    int cycle = 0;
    bit done = 1'b0;
    bit mem_stall = 1'b0;

    // behavioural model: 0 free, 1 to request, 2 awaiting data, 3 held
    int            m_st[2];
    logic [TW-1:0] m_tag[2];
    int            m_rr;
    logic [TW-1:0] mq[$];
    int            mq_due[$];

    logic obs_hit, obs_fill, obs_rv;
    logic [31:0] obs_radr;
    logic [255:0] obs_fdata;

    function automatic logic [255:0] mk_line(input logic [TW-1:0] b);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = {5'(w), b};
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cycle, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare, advance model
    task automatic cyc(input logic v, input logic [TW-1:0] b, input logic [4:0] ofs,
                       input logic ch, input logic rdy);
        int h, r, vic;
        bit e_hit, e_fill, e_rv, yld, live, rsp;
        logic [TW-1:0] t;
        lk_valid = v; lk_addr = {b, ofs}; lk_cache_hit = ch; mem_req_ready = rdy;
        rsp = !mem_stall && mq.size() > 0 && mq_due[0] <= cycle;
        mem_rsp_valid = rsp;
        mem_rsp_addr  = rsp ? {mq[0], 5'b10101} : '0;
        mem_rsp_data  = rsp ? mk_line(mq[0]) : '0;
        #1;
        h = -1;
        for (int e = 0; e < 2; e++) if (v && m_st[e] == 3 && m_tag[e] == b) h = e;
        e_hit = (h >= 0);
        e_fill = e_hit && !ch;
        yld = v && !ch && !e_hit;
        r = -1;
        for (int e = 1; e >= 0; e--) if (m_st[e] == 1) r = e;
        e_rv = (r >= 0) && !yld;
        obs_hit = lk_buf_hit; obs_fill = fill_valid; obs_rv = mem_req_valid;
        obs_radr = mem_req_addr; obs_fdata = fill_data;
        chk(lk_buf_hit == e_hit, "R2 hit", 256'(lk_buf_hit), 256'(e_hit));
        chk(fill_valid == e_fill, "R2 fill", 256'(fill_valid), 256'(e_fill));
        if (e_fill) begin
            chk(fill_data == mk_line(b), "R2 data", fill_data, mk_line(b));
            chk(fill_addr == {b, 5'b0}, "R2 addr", 256'(fill_addr), 256'({b, 5'b0}));
        end
        chk(mem_req_valid == e_rv, "R4 R7 req", 256'(mem_req_valid), 256'(e_rv));
        if (e_rv)
            chk(mem_req_addr == {m_tag[r], 5'b0}, "R9 R10 addr",
                256'(mem_req_addr), 256'({m_tag[r], 5'b0}));
        // model update in the order the next edge applies
        if (rsp) begin
            for (int e = 0; e < 2; e++) if (m_st[e] == 2 && m_tag[e] == mq[0]) m_st[e] = 3;
            void'(mq.pop_front()); void'(mq_due.pop_front());
        end
        if (e_rv && rdy) begin
            m_st[r] = 2; mq.push_back(m_tag[r]); mq_due.push_back(cycle + LAT);
        end
        if (e_hit) m_st[h] = 0;
        t = b + 1'b1;
        live = 1'b0;
        for (int e = 0; e < 2; e++) if (m_st[e] != 0 && m_tag[e] == t) live = 1'b1;
        if (v && !live) begin
            vic = -1;
            for (int e = 1; e >= 0; e--) if (m_st[e] == 0) vic = e;
            if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % 2; end
            m_st[vic] = 1; m_tag[vic] = t;
        end
        cycle++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 5'd0, 1'b0, 1'b1);
    endtask

    initial begin
        logic [TW-1:0] cur;
        for (int e = 0; e < 2; e++) begin m_st[e] = 0; m_tag[e] = '0; end
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_req_valid == 1'b0, "R1 req", 256'(mem_req_valid), 256'(0));
        chk(lk_buf_hit == 1'b0, "R1 hit", 256'(lk_buf_hit), 256'(0));
        @(negedge clk);

        cyc(1'b1, 27'd10, 5'd4, 1'b0, 1'b1);
        chk(obs_rv == 1'b0, "R7", 256'(obs_rv), 256'(0));
        idle(1);
        chk(obs_rv && obs_radr == 32'(11 * 32), "R4 R9", 256'(obs_radr), 256'(11 * 32));
        idle(1);
        chk(obs_rv == 1'b0, "R10", 256'(obs_rv), 256'(0));
        idle(4);
        cyc(1'b1, 27'd10, 5'd9, 1'b1, 1'b1);
        idle(1);
        chk(obs_rv == 1'b0, "R5", 256'(obs_rv), 256'(0));
        cyc(1'b1, 27'd11, 5'd7, 1'b0, 1'b1);
        chk(obs_hit && obs_fill && obs_fdata == mk_line(27'd11), "R2", obs_fdata,
            mk_line(27'd11));
        cyc(1'b1, 27'd11, 5'd0, 1'b0, 1'b1);
        chk(obs_hit == 1'b0, "R3", 256'(obs_hit), 256'(0));
        chk(obs_rv == 1'b0, "R7 pending", 256'(obs_rv), 256'(0));
        idle(1);
        chk(obs_rv && obs_radr == 32'(12 * 32), "R4", 256'(obs_radr), 256'(12 * 32));
        idle(4);
        cyc(1'b1, 27'd12, 5'd0, 1'b1, 1'b1);
        chk(obs_hit && !obs_fill, "R2 cache hit", 256'({obs_hit, obs_fill}), 256'(2));

        // R6 R8: overwrite both entries while their reads are outstanding
        mem_stall = 1'b1;
        idle(1);
        cyc(1'b1, 27'd40, 5'd0, 1'b0, 1'b1); idle(1);
        cyc(1'b1, 27'd50, 5'd0, 1'b0, 1'b1); idle(1);
        cyc(1'b1, 27'd60, 5'd0, 1'b0, 1'b1); idle(1);
        mem_stall = 1'b0;
        idle(6);
        cyc(1'b1, 27'd61, 5'd0, 1'b0, 1'b1);
        chk(obs_hit == 1'b1, "R6 61", 256'(obs_hit), 256'(1));
        cyc(1'b1, 27'd51, 5'd0, 1'b0, 1'b1);
        chk(obs_hit == 1'b1, "R6 51", 256'(obs_hit), 256'(1));
        cyc(1'b1, 27'd41, 5'd0, 1'b0, 1'b1);
        chk(obs_hit == 1'b0, "R8 41", 256'(obs_hit), 256'(0));
        cyc(1'b1, 27'd13, 5'd0, 1'b0, 1'b1);
        chk(obs_hit == 1'b0, "R8 13", 256'(obs_hit), 256'(0));

        // R4 wrap past the last block
        idle(10);
        cyc(1'b1, {TW{1'b1}}, 5'd31, 1'b1, 1'b1);
        idle(1);
        chk(obs_rv && obs_radr == 32'd0, "R4 wrap", 256'(obs_radr), 256'(0));
        idle(6);

        // mixed streams, jumps, ready and cache-hit toggling
        cur = 27'd100;
        for (int i = 0; i < 3000; i++) begin
            bit v;
            v = ($urandom_range(0, 9) < 6);
            if (v) begin
                if ($urandom_range(0, 9) < 6) cur = cur + 1'b1;
                else if ($urandom_range(0, 1) == 0) cur = 27'($urandom_range(96, 112));
            end
            mem_stall = ($urandom_range(0, 19) == 0);
            cyc(v, cur, 5'($urandom_range(0, 31)), ($urandom_range(0, 9) < 3),
                ($urandom_range(0, 9) < 7));
        end
        mem_stall = 1'b0;
        idle(4);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cycle);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule